// File: doc/BRIEF.md
# Write-Recovery Timing Guard for a Multi-Bank DDR Controller

This block sits in the command path of a double-data-rate memory controller. It watches every command addressed to the memory banks and decides, cycle by cycle, whether that command may go out. For each bank it records whether a row is open, whether the data pairs of a write burst are still arriving, how much of the write-to-read and write-recovery intervals is left after the final pair, and how much of the precharge interval is left after a bank closes. The three intervals are loaded from configuration inputs.

A legal command is passed on one cycle later. An illegal one is dropped and a one-cycle violation pulse names the bank and the broken rule. A read or precharge that arrives while the write data is still arriving is legal and cuts the burst short. The guard marks such a command as truncating and reports how many data pairs of the burst must be masked. A per-bank set of allow flags tells the scheduler in advance which commands would be accepted in the current cycle.

Top module: `wr_recovery_guard`

## Requirements
- R1: Command codes on `cmd_kind` are 0 idle, 1 activate, 2 write, 3 read, 4 precharge; codes 5 to 7 act as idle. A legal command sampled at edge k appears on `fwd_valid`/`fwd_kind`/`fwd_bank` for the cycle after edge k. An illegal one is not forwarded and raises `viol_valid` for that single cycle with `viol_bank` and `viol_rule` (0 precharge time, 1 bank state, 2 write-to-read, 3 write recovery).
- R2: A write sampled at edge E0 with `cmd_pairs` = N registers its data pairs at edges E1..EN. A write to an open bank with no pending auto-precharge is always legal, and a new write restarts the burst count of that bank.
- R3: A read to a bank whose burst has ended is legal at edge Ej only when j >= N+1+twtr; for N < j < N+1+twtr it is rejected with rule 2.
- R4: A read at edge Ej with 1 <= j <= N is legal and truncating: `fwd_trunc` and `mask_valid` are 1 and `mask_pairs` = min(N, (N-j+1)+twtr).
- R5: A precharge to a bank whose burst has ended is legal at edge Ej only when j >= N+1+twr; for N < j < N+1+twr it is rejected with rule 3.
- R6: A precharge at edge Ej with 1 <= j <= N is legal and truncating, with `mask_pairs` = min(N, (N-j+1)+twr); it closes the bank.
- R7: After a precharge accepted at edge Ej, any command to that bank at an edge before E(j+1+trp) is rejected with rule 0. An activate at that edge or later is legal.
- R8: A write with `cmd_auto_pre` set closes its bank at edge E(N+1+twr), the earliest edge at which an explicit precharge would be legal. An activate to that bank is then legal from edge E(N+2+twr+trp).
- R9: A read, write or precharge to a closed bank or to a bank with a pending auto-precharge, and an activate to an open bank, are rejected with rule 1. The precharge-time rule 0 takes precedence over rule 1.
- R10: `allow_act`, `allow_wr`, `allow_rd` and `allow_pre` bit b are 1 exactly when that command to bank b would be accepted in the current cycle, including truncating commands. After reset every bank is closed: `allow_act` is all ones and the other three are all zeros.
- R11: Each bank keeps its own timing state. A command to one bank leaves the legality and masking results of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_kind | input | 3 | Command code for this cycle |
| cmd_bank | input | BANK_W | Addressed bank |
| cmd_auto_pre | input | 1 | Write closes its bank automatically after recovery |
| cmd_pairs | input | BURST_W | Data pairs in the write burst (1 or more) |
| cfg_twtr | input | CNT_W | Write-to-read interval in cycles |
| cfg_twr | input | CNT_W | Write-recovery interval in cycles |
| cfg_trp | input | CNT_W | Precharge interval in cycles |
| allow_act | output | NUM_BANKS | Activate would be accepted, per bank |
| allow_wr | output | NUM_BANKS | Write would be accepted, per bank |
| allow_rd | output | NUM_BANKS | Read would be accepted, per bank |
| allow_pre | output | NUM_BANKS | Precharge would be accepted, per bank |
| fwd_valid | output | 1 | A legal command is forwarded |
| fwd_kind | output | 3 | Code of the forwarded command |
| fwd_bank | output | BANK_W | Bank of the forwarded command |
| fwd_trunc | output | 1 | Forwarded command cuts a write burst short |
| mask_valid | output | 1 | Data pairs of the cut burst must be masked |
| mask_pairs | output | BURST_W | Number of pairs to mask |
| viol_valid | output | 1 | One-cycle pulse for a rejected command |
| viol_bank | output | BANK_W | Bank of the rejected command |
| viol_rule | output | 2 | Timing or state rule that was broken |

## Verification
The sharpest overlap comes when a read or precharge arrives at the same edge as the final data pair of a burst. The end-of-burst load of the recovery counters then competes with the truncation, and the truncation must win with a mask count of min(N, 1+interval). The bench sweeps the issue edge of reads and precharges across every position of a burst and just past it, so this edge is hit on every sweep. The second overlap is an auto-precharge closing a bank in the same cycle that an activate is presented to it. The activate sweep after an auto-precharge write crosses that edge and expects a bank-state rejection there, followed by precharge-time rejections until the interval has passed.

// File: rtl/wrg_pkg.sv
package wrg_pkg;

   typedef enum logic [2:0] {
      CMD_IDLE  = 3'd0,
      CMD_ACT   = 3'd1,
      CMD_WRITE = 3'd2,
      CMD_READ  = 3'd3,
      CMD_PRE   = 3'd4
   } cmd_e;

   typedef enum logic [1:0] {
      RULE_PRE_TIME = 2'd0,
      RULE_STATE    = 2'd1,
      RULE_WR2RD    = 2'd2,
      RULE_WR_REC   = 2'd3
   } rule_e;

   // Condensed view of one bank's timing state.
   typedef struct packed {
      logic is_open;
      logic ap_pend;
      logic in_burst;
      logic wtr_wait;
      logic wrec_wait;
      logic rp_wait;
   } bank_flags_t;

   typedef struct packed {
      logic  legal;
      logic  trunc;
      rule_e rule;
   } verdict_t;

   // Legality of one command against one bank's state.
   function automatic verdict_t judge_cmd(input logic [2:0] kind, input bank_flags_t f);
      verdict_t v;
      v.legal = 1'b0;
      v.trunc = 1'b0;
      v.rule  = RULE_STATE;
      if (f.rp_wait) begin
         v.rule = RULE_PRE_TIME;
      end else begin
         case (kind)
            CMD_ACT:   v.legal = !f.is_open;
            CMD_WRITE: v.legal = f.is_open && !f.ap_pend;
            CMD_READ: begin
               if (f.is_open && !f.ap_pend) begin
                  if (f.in_burst) begin
                     v.legal = 1'b1;
                     v.trunc = 1'b1;
                  end else if (f.wtr_wait) begin
                     v.rule = RULE_WR2RD;
                  end else begin
                     v.legal = 1'b1;
                  end
               end
            end
            CMD_PRE: begin
               if (f.is_open && !f.ap_pend) begin
                  if (f.in_burst) begin
                     v.legal = 1'b1;
                     v.trunc = 1'b1;
                  end else if (f.wrec_wait) begin
                     v.rule = RULE_WR_REC;
                  end else begin
                     v.legal = 1'b1;
                  end
               end
            end
            default: v.legal = 1'b0;
         endcase
      end
      return v;
   endfunction

   function automatic logic would_accept(input logic [2:0] kind, input bank_flags_t f);
      verdict_t v;
      v = judge_cmd(kind, f);
      return v.legal;
   endfunction

endpackage

// File: rtl/wrg_bank_tracker.sv
module wrg_bank_tracker
   import wrg_pkg::*;
#(
   parameter int CNT_W   = 4,
   parameter int BURST_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit,
   input  logic [2:0]         hit_kind,
   input  logic               hit_ap,
   input  logic [BURST_W-1:0] hit_pairs,
   input  logic [CNT_W-1:0]   cfg_twtr,
   input  logic [CNT_W-1:0]   cfg_twr,
   input  logic [CNT_W-1:0]   cfg_trp,
   output bank_flags_t        flags,
   output logic [BURST_W-1:0] rem,
   output logic [BURST_W-1:0] blen,
   output logic               allow_act,
   output logic               allow_wr,
   output logic               allow_rd,
   output logic               allow_pre
);

   localparam logic [BURST_W-1:0] PAIR_ONE = BURST_W'(1);
   localparam logic [CNT_W-1:0]   CNT_ONE  = CNT_W'(1);

   logic               open_q, open_d;
   logic               ap_q, ap_d;
   logic [BURST_W-1:0] rem_q, rem_d;
   logic [BURST_W-1:0] blen_q, blen_d;
   logic [CNT_W-1:0]   wtr_q, wtr_d;
   logic [CNT_W-1:0]   wr_q, wr_d;
   logic [CNT_W-1:0]   rp_q, rp_d;

   always_comb begin
      open_d = open_q;
      ap_d   = ap_q;
      rem_d  = rem_q;
      blen_d = blen_q;
      wtr_d  = wtr_q;
      wr_d   = wr_q;
      rp_d   = rp_q;

      // Free-running progress of the bank's intervals.
      if (rp_q != '0) rp_d = rp_q - CNT_ONE;
      if (rem_q != '0) begin
         rem_d = rem_q - PAIR_ONE;
         if (rem_q == PAIR_ONE) begin
            wtr_d = cfg_twtr;
            wr_d  = cfg_twr;
         end
      end else begin
         if (wtr_q != '0) wtr_d = wtr_q - CNT_ONE;
         if (wr_q != '0)  wr_d  = wr_q - CNT_ONE;
         if (ap_q && open_q && (wr_q == '0)) begin
            open_d = 1'b0;
            ap_d   = 1'b0;
            rp_d   = cfg_trp;
         end
      end

      // An accepted command overrides the progress.
      if (hit) begin
         case (hit_kind)
            CMD_ACT: open_d = 1'b1;
            CMD_WRITE: begin
               rem_d  = hit_pairs;
               blen_d = hit_pairs;
               ap_d   = hit_ap;
               wtr_d  = '0;
               wr_d   = '0;
            end
            CMD_READ: begin
               if (rem_q != '0) begin
                  rem_d = '0;
                  wtr_d = '0;
                  wr_d  = '0;
               end
            end
            CMD_PRE: begin
               open_d = 1'b0;
               ap_d   = 1'b0;
               rem_d  = '0;
               wtr_d  = '0;
               wr_d   = '0;
               rp_d   = cfg_trp;
            end
            default: open_d = open_d;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         ap_q   <= 1'b0;
         rem_q  <= '0;
         blen_q <= '0;
         wtr_q  <= '0;
         wr_q   <= '0;
         rp_q   <= '0;
      end else begin
         open_q <= open_d;
         ap_q   <= ap_d;
         rem_q  <= rem_d;
         blen_q <= blen_d;
         wtr_q  <= wtr_d;
         wr_q   <= wr_d;
         rp_q   <= rp_d;
      end
   end

   assign flags = '{is_open:   open_q,
                    ap_pend:   ap_q,
                    in_burst:  (rem_q != '0),
                    wtr_wait:  (wtr_q != '0),
                    wrec_wait: (wr_q != '0),
                    rp_wait:   (rp_q != '0)};
   assign rem  = rem_q;
   assign blen = blen_q;

   assign allow_act = would_accept(CMD_ACT,   flags);
   assign allow_wr  = would_accept(CMD_WRITE, flags);
   assign allow_rd  = would_accept(CMD_READ,  flags);
   assign allow_pre = would_accept(CMD_PRE,   flags);

   // Precharge interval counts down one per cycle when nothing touches the bank.
   assert_rp_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rp_q != '0 && !hit) |=> (rp_q == $past(rp_q) - CNT_ONE));

   // A bank inside its precharge interval is never open.
   assert_closed_during_rp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rp_q != '0) |-> !open_q);

   // The edge of the final pair starts the write-to-read interval.
   assert_wtr_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_q == PAIR_ONE && !hit) |=> (wtr_q == $past(cfg_twtr)));

   // Auto-precharge closes the bank once recovery has elapsed.
   assert_auto_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ap_q && open_q && rem_q == '0 && wr_q == '0 && !hit) |=>
      (!open_q && rp_q == $past(cfg_trp)));

endmodule

// File: rtl/wrg_mask_calc.sv
module wrg_mask_calc #(
   parameter int CNT_W   = 4,
   parameter int BURST_W = 4
) (
   input  logic [BURST_W-1:0] rem,
   input  logic [BURST_W-1:0] blen,
   input  logic [CNT_W-1:0]   span,
   output logic [BURST_W-1:0] pairs
);

   localparam int SUM_W = ((CNT_W > BURST_W) ? CNT_W : BURST_W) + 1;

   logic [SUM_W-1:0] sum;

   // Pairs still to come plus those registered within the interval, capped at the burst.
   assign sum   = SUM_W'(rem) + SUM_W'(span);
   assign pairs = (sum > SUM_W'(blen)) ? blen : sum[BURST_W-1:0];

endmodule

// File: rtl/wrg_bank_select.sv
module wrg_bank_select
   import wrg_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BURST_W   = 4,
   parameter int BANK_W    = 2
) (
   input  bank_flags_t        flags_arr [NUM_BANKS],
   input  logic [BURST_W-1:0] rem_arr   [NUM_BANKS],
   input  logic [BURST_W-1:0] blen_arr  [NUM_BANKS],
   input  logic [BANK_W-1:0]  sel,
   output bank_flags_t        sel_flags,
   output logic [BURST_W-1:0] sel_rem,
   output logic [BURST_W-1:0] sel_blen
);

   assign sel_flags = flags_arr[sel];
   assign sel_rem   = rem_arr[sel];
   assign sel_blen  = blen_arr[sel];

endmodule

// File: rtl/wr_recovery_guard.sv
module wr_recovery_guard
   import wrg_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int CNT_W     = 4,
   parameter int BURST_W   = 4,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           cmd_kind,
   input  logic [BANK_W-1:0]    cmd_bank,
   input  logic                 cmd_auto_pre,
   input  logic [BURST_W-1:0]   cmd_pairs,
   input  logic [CNT_W-1:0]     cfg_twtr,
   input  logic [CNT_W-1:0]     cfg_twr,
   input  logic [CNT_W-1:0]     cfg_trp,
   output logic [NUM_BANKS-1:0] allow_act,
   output logic [NUM_BANKS-1:0] allow_wr,
   output logic [NUM_BANKS-1:0] allow_rd,
   output logic [NUM_BANKS-1:0] allow_pre,
   output logic                 fwd_valid,
   output logic [2:0]           fwd_kind,
   output logic [BANK_W-1:0]    fwd_bank,
   output logic                 fwd_trunc,
   output logic                 mask_valid,
   output logic [BURST_W-1:0]   mask_pairs,
   output logic                 viol_valid,
   output logic [BANK_W-1:0]    viol_bank,
   output logic [1:0]           viol_rule
);

   // Elaboration-time parameter checks.
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (CNT_W < 4) begin : g_bad_cnt
      $error("CNT_W must be at least 4");
   end
   if (BURST_W < 1) begin : g_bad_burst
      $error("BURST_W must be at least 1");
   end

   bank_flags_t        flags_arr [NUM_BANKS];
   logic [BURST_W-1:0] rem_arr   [NUM_BANKS];
   logic [BURST_W-1:0] blen_arr  [NUM_BANKS];
   logic [NUM_BANKS-1:0] hit_vec;

   bank_flags_t        sel_flags;
   logic [BURST_W-1:0] sel_rem;
   logic [BURST_W-1:0] sel_blen;
   logic [BURST_W-1:0] mask_now;
   logic [CNT_W-1:0]   span;
   verdict_t           verdict;
   logic               is_cmd;
   logic               accept;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign hit_vec[b] = accept && (cmd_bank == BANK_W'(b));

      wrg_bank_tracker #(
         .CNT_W   (CNT_W),
         .BURST_W (BURST_W)
      ) u_trk (
         .clk       (clk),
         .rst_n     (rst_n),
         .hit       (hit_vec[b]),
         .hit_kind  (cmd_kind),
         .hit_ap    (cmd_auto_pre),
         .hit_pairs (cmd_pairs),
         .cfg_twtr  (cfg_twtr),
         .cfg_twr   (cfg_twr),
         .cfg_trp   (cfg_trp),
         .flags     (flags_arr[b]),
         .rem       (rem_arr[b]),
         .blen      (blen_arr[b]),
         .allow_act (allow_act[b]),
         .allow_wr  (allow_wr[b]),
         .allow_rd  (allow_rd[b]),
         .allow_pre (allow_pre[b])
      );
   end

   wrg_bank_select #(
      .NUM_BANKS (NUM_BANKS),
      .BURST_W   (BURST_W),
      .BANK_W    (BANK_W)
   ) u_sel (
      .flags_arr (flags_arr),
      .rem_arr   (rem_arr),
      .blen_arr  (blen_arr),
      .sel       (cmd_bank),
      .sel_flags (sel_flags),
      .sel_rem   (sel_rem),
      .sel_blen  (sel_blen)
   );

   assign span = (cmd_kind == CMD_READ) ? cfg_twtr : cfg_twr;

   wrg_mask_calc #(
      .CNT_W   (CNT_W),
      .BURST_W (BURST_W)
   ) u_mask (
      .rem   (sel_rem),
      .blen  (sel_blen),
      .span  (span),
      .pairs (mask_now)
   );

   assign is_cmd  = (cmd_kind >= 3'd1) && (cmd_kind <= 3'd4);
   assign verdict = judge_cmd(cmd_kind, sel_flags);
   assign accept  = is_cmd && verdict.legal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_valid  <= 1'b0;
         fwd_kind   <= 3'd0;
         fwd_bank   <= '0;
         fwd_trunc  <= 1'b0;
         mask_valid <= 1'b0;
         mask_pairs <= '0;
         viol_valid <= 1'b0;
         viol_bank  <= '0;
         viol_rule  <= 2'd0;
      end else begin
         fwd_valid  <= accept;
         fwd_kind   <= accept ? cmd_kind : 3'd0;
         fwd_bank   <= cmd_bank;
         fwd_trunc  <= accept && verdict.trunc;
         mask_valid <= accept && verdict.trunc;
         mask_pairs <= (accept && verdict.trunc) ? mask_now : '0;
         viol_valid <= is_cmd && !verdict.legal;
         viol_bank  <= cmd_bank;
         viol_rule  <= (is_cmd && !verdict.legal) ? verdict.rule : RULE_PRE_TIME;
      end
   end

   // Previous-cycle allow flags, kept for the cross-checks below.
   logic [NUM_BANKS-1:0] act_prev, rd_prev;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_prev <= '0;
         rd_prev  <= '0;
      end else begin
         act_prev <= allow_act;
         rd_prev  <= allow_rd;
      end
   end

   // A forwarded activate was announced as allowed by its bank's flags.
   assert_fwd_act_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && fwd_kind == CMD_ACT) |-> act_prev[fwd_bank]);

   // A forwarded read was announced as allowed by its bank's flags.
   assert_fwd_rd_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && fwd_kind == CMD_READ) |-> rd_prev[fwd_bank]);

   // A mask request never asks for zero pairs.
   assert_mask_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mask_valid |-> (mask_pairs != '0));

   // A violation pulse follows a presented command.
   assert_viol_has_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid |-> ($past(cmd_kind) != 3'd0));

endmodule

// File: tb/wr_recovery_guard_tb.sv
module wr_recovery_guard_tb;

   localparam int NB = 4;
   localparam int CW = 4;
   localparam int BW = 4;
   localparam int K_IDLE = 0, K_ACT = 1, K_WR = 2, K_RD = 3, K_PRE = 4;
   localparam int R_RP = 0, R_ST = 1, R_WTR = 2, R_WREC = 3;
   localparam int TWTR = 2, TWR = 3, TRP = 2, NP = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n;
   logic [2:0]    cmd_kind;
   logic [1:0]    cmd_bank;
   logic          cmd_auto_pre;
   logic [BW-1:0] cmd_pairs;
   logic [CW-1:0] cfg_twtr, cfg_twr, cfg_trp;
   logic [NB-1:0] allow_act, allow_wr, allow_rd, allow_pre;
   logic          fwd_valid, fwd_trunc, mask_valid, viol_valid;
   logic [2:0]    fwd_kind;
   logic [1:0]    fwd_bank, viol_bank, viol_rule;
   logic [BW-1:0] mask_pairs;

   wr_recovery_guard #(.NUM_BANKS(NB), .CNT_W(CW), .BURST_W(BW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
      .cmd_auto_pre(cmd_auto_pre), .cmd_pairs(cmd_pairs),
      .cfg_twtr(cfg_twtr), .cfg_twr(cfg_twr), .cfg_trp(cfg_trp),
      .allow_act(allow_act), .allow_wr(allow_wr), .allow_rd(allow_rd), .allow_pre(allow_pre),
      .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_bank(fwd_bank), .fwd_trunc(fwd_trunc),
      .mask_valid(mask_valid), .mask_pairs(mask_pairs),
      .viol_valid(viol_valid), .viol_bank(viol_bank), .viol_rule(viol_rule));

   typedef struct {
      bit    fwd;
      int    kind;
      int    bank;
      bit    trunc;
      int    mask;
      bit    viol;
      int    rule;
      string req;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic exp_t quiet();
      exp_t e;
      e.fwd = 0; e.kind = 0; e.bank = 0; e.trunc = 0; e.mask = 0; e.viol = 0; e.rule = 0; e.req = "R1";
      return e;
   endfunction

   function automatic exp_t ok_e(input int kind, input int bank, input bit trunc, input int mask, input string req);
      exp_t e = quiet();
      e.fwd = 1; e.kind = kind; e.bank = bank; e.trunc = trunc; e.mask = mask; e.req = req;
      return e;
   endfunction

   function automatic exp_t bad_e(input int bank, input int rule, input string req);
      exp_t e = quiet();
      e.viol = 1; e.bank = bank; e.rule = rule; e.req = req;
      return e;
   endfunction

   function automatic int imin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   // Driver: present one command for one cycle, check its allow flag, queue the expectation.
   task automatic issue(input int kind, input int bank, input bit ap, input int pairs,
                        input exp_t e, input int allow_exp);
      logic [NB-1:0] av;
      @(negedge clk);
      cmd_kind     = 3'(kind);
      cmd_bank     = 2'(bank);
      cmd_auto_pre = ap;
      cmd_pairs    = BW'(pairs);
      if (allow_exp >= 0) begin
         case (kind)
            K_ACT:   av = allow_act;
            K_WR:    av = allow_wr;
            K_RD:    av = allow_rd;
            default: av = allow_pre;
         endcase
         chk(av[bank] == allow_exp[0], e.req, "allow flag", int'(av[bank]), allow_exp);
      end
      q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) issue(K_IDLE, 0, 0, 0, quiet(), -1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      cmd_kind = 3'd0; cmd_bank = 2'd0; cmd_auto_pre = 1'b0; cmd_pairs = '0;
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Monitor: compare registered outputs with the queued expectation.
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(fwd_valid == e.fwd, e.req, "fwd_valid", int'(fwd_valid), int'(e.fwd));
            chk(viol_valid == e.viol, e.req, "viol_valid", int'(viol_valid), int'(e.viol));
            chk(mask_valid == e.trunc, e.req, "mask_valid", int'(mask_valid), int'(e.trunc));
            if (e.fwd) begin
               chk(int'(fwd_kind) == e.kind && int'(fwd_bank) == e.bank, e.req, "fwd kind*4+bank",
                   int'(fwd_kind) * 4 + int'(fwd_bank), e.kind * 4 + e.bank);
               chk(fwd_trunc == e.trunc, e.req, "fwd_trunc", int'(fwd_trunc), int'(e.trunc));
               chk(int'(mask_pairs) == e.mask, e.req, "mask_pairs", int'(mask_pairs), e.mask);
            end
            if (e.viol) begin
               chk(int'(viol_bank) == e.bank, e.req, "viol_bank", int'(viol_bank), e.bank);
               chk(int'(viol_rule) == e.rule, e.req, "viol_rule", int'(viol_rule), e.rule);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      cmd_kind = 3'd0; cmd_bank = 2'd0; cmd_auto_pre = 1'b0; cmd_pairs = '0;
      cfg_twtr = CW'(TWTR); cfg_twr = CW'(TWR); cfg_trp = CW'(TRP);
      do_reset();

      // R10: reset state of the allow flags and outputs.
      @(negedge clk);
      chk(allow_act == '1, "R10", "allow_act after reset", int'(allow_act), 15);
      chk(allow_rd == '0 && allow_wr == '0 && allow_pre == '0, "R10", "rd|wr|pre after reset",
          int'(allow_rd | allow_wr | allow_pre), 0);
      chk(!fwd_valid && !viol_valid && !mask_valid, "R10", "outputs after reset",
          int'(fwd_valid) + int'(viol_valid) + int'(mask_valid), 0);

      // R3/R4: read issue edge swept across the burst and the write-to-read interval.
      for (int j = 1; j <= NP + TWTR + 2; j++) begin
         bit legal, trunc;
         do_reset();
         issue(K_ACT, 0, 0, 0, ok_e(K_ACT, 0, 0, 0, "R1"), 1);
         issue(K_WR, 0, 0, NP, ok_e(K_WR, 0, 0, 0, "R2"), 1);
         idle(j - 1);
         trunc = (j <= NP);
         legal = trunc || (j >= NP + 1 + TWTR);
         if (trunc)      issue(K_RD, 0, 0, 0, ok_e(K_RD, 0, 1, imin(NP, NP - j + 1 + TWTR), "R4"), 1);
         else if (legal) issue(K_RD, 0, 0, 0, ok_e(K_RD, 0, 0, 0, "R3"), 1);
         else            issue(K_RD, 0, 0, 0, bad_e(0, R_WTR, "R3"), 0);
      end

      // R5/R6: precharge issue edge swept across the burst and write recovery.
      for (int j = 1; j <= NP + TWR + 2; j++) begin
         bit legal, trunc;
         do_reset();
         issue(K_ACT, 2, 0, 0, ok_e(K_ACT, 2, 0, 0, "R1"), 1);
         issue(K_WR, 2, 0, NP, ok_e(K_WR, 2, 0, 0, "R2"), 1);
         idle(j - 1);
         trunc = (j <= NP);
         legal = trunc || (j >= NP + 1 + TWR);
         if (trunc)      issue(K_PRE, 2, 0, 0, ok_e(K_PRE, 2, 1, imin(NP, NP - j + 1 + TWR), "R6"), 1);
         else if (legal) issue(K_PRE, 2, 0, 0, ok_e(K_PRE, 2, 0, 0, "R5"), 1);
         else            issue(K_PRE, 2, 0, 0, bad_e(2, R_WREC, "R5"), 0);
      end

      // R7: activate swept after a precharge.
      for (int d = 0; d <= TRP + 1; d++) begin
         do_reset();
         issue(K_ACT, 1, 0, 0, ok_e(K_ACT, 1, 0, 0, "R7"), 1);
         issue(K_PRE, 1, 0, 0, ok_e(K_PRE, 1, 0, 0, "R7"), 1);
         idle(d);
         if (d >= TRP) issue(K_ACT, 1, 0, 0, ok_e(K_ACT, 1, 0, 0, "R7"), 1);
         else          issue(K_ACT, 1, 0, 0, bad_e(1, R_RP, "R7"), 0);
      end

      // R8: activate swept after an auto-precharge write.
      for (int k = NP + 1; k <= NP + TWR + TRP + 3; k++) begin
         do_reset();
         issue(K_ACT, 3, 0, 0, ok_e(K_ACT, 3, 0, 0, "R8"), 1);
         issue(K_WR, 3, 1, NP, ok_e(K_WR, 3, 0, 0, "R8"), 1);
         idle(k - 1);
         if (k <= NP + 1 + TWR)            issue(K_ACT, 3, 0, 0, bad_e(3, R_ST, "R8"), 0);
         else if (k < NP + 2 + TWR + TRP)  issue(K_ACT, 3, 0, 0, bad_e(3, R_RP, "R8"), 0);
         else                              issue(K_ACT, 3, 0, 0, ok_e(K_ACT, 3, 0, 0, "R8"), 1);
      end

      // R9: state rules and precedence of the precharge-time rule.
      do_reset();
      issue(K_RD, 0, 0, 0, bad_e(0, R_ST, "R9"), 0);
      issue(K_ACT, 0, 0, 0, ok_e(K_ACT, 0, 0, 0, "R9"), 1);
      issue(K_ACT, 0, 0, 0, bad_e(0, R_ST, "R9"), 0);
      issue(K_PRE, 0, 0, 0, ok_e(K_PRE, 0, 0, 0, "R9"), 1);
      issue(K_RD, 0, 0, 0, bad_e(0, R_RP, "R9"), 0);
      issue(K_WR, 1, 0, NP, bad_e(1, R_ST, "R9"), 0);
      issue(K_PRE, 2, 0, 0, bad_e(2, R_ST, "R9"), 0);
      issue(K_ACT, 1, 0, 0, ok_e(K_ACT, 1, 0, 0, "R9"), 1);
      issue(K_WR, 1, 1, NP, ok_e(K_WR, 1, 0, 0, "R9"), 1);
      idle(NP);
      issue(K_RD, 1, 0, 0, bad_e(1, R_ST, "R9"), 0);
      issue(7, 1, 0, 0, quiet(), -1);

      // R11: a read to another bank leaves the burst on bank 0 untouched.
      do_reset();
      issue(K_ACT, 0, 0, 0, ok_e(K_ACT, 0, 0, 0, "R11"), 1);
      issue(K_ACT, 1, 0, 0, ok_e(K_ACT, 1, 0, 0, "R11"), 1);
      issue(K_WR, 0, 0, NP, ok_e(K_WR, 0, 0, 0, "R11"), 1);
      issue(K_RD, 1, 0, 0, ok_e(K_RD, 1, 0, 0, "R11"), 1);
      issue(K_RD, 0, 0, 0, ok_e(K_RD, 0, 1, imin(NP, NP - 2 + 1 + TWTR), "R11"), 1);

      // R2: a second write restarts the burst; read on its final pair edge.
      do_reset();
      issue(K_ACT, 0, 0, 0, ok_e(K_ACT, 0, 0, 0, "R2"), 1);
      issue(K_WR, 0, 0, NP, ok_e(K_WR, 0, 0, 0, "R2"), 1);
      idle(1);
      issue(K_WR, 0, 0, NP, ok_e(K_WR, 0, 0, 0, "R2"), 1);
      idle(NP - 1);
      issue(K_RD, 0, 0, 0, ok_e(K_RD, 0, 1, imin(NP, 1 + TWTR), "R2"), 1);

      idle(3);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule